// File: doc/BRIEF.md
# Keyed One-Shot Watchdog Timer

This block is a watchdog timer that listens on an 8-bit register write bus. After reset it does nothing. Software arms it by writing a two-byte key to one service address: first 1EH, then E1H. From then on a counter advances once per machine-cycle strobe. If software does not repeat the same key pair in time, the counter reaches its terminal value and the block raises a reset request pulse.

Software cannot stop or slow the armed watchdog. No other write turns it off, and the count can be neither read nor loaded. Only a hardware reset or the watchdog's own overflow returns it to the disarmed state. The service address is write-only and has no read path. The count width, pulse length, bus widths, service address and key bytes are all parameters.

Top module: `wdog_keyed`

## Requirements
- R1: While `rst` is high, and on every cycle after it until the key is written, `rst_req` stays low. A disarmed watchdog never raises `rst_req`, however many `mc_tick` strobes it sees. Reset also clears any partly entered key.
- R2: The watchdog arms only when a write of KEY_A (1EH) to SVC_ADDR (A6H) is followed by a write of KEY_B (E1H) to SVC_ADDR, with no other SVC_ADDR write between them. Any other SVC_ADDR write aborts a partial key, including a second KEY_A. After an abort the sequence again waits for KEY_A, and a lone KEY_B arms nothing.
- R3: When armed, the count advances by one on each clock edge at which `mc_tick` is high. Edges with `mc_tick` low leave the count unchanged.
- R4: Overflow happens on the tick that would bring the count to 2^CNT_W-1. That is the (2^CNT_W-1)-th tick after arming or after the last service. `rst_req` goes high at the clock edge that takes that tick.
- R5: Each overflow holds `rst_req` high for exactly PULSE_LEN consecutive clock cycles.
- R6: An overflow disarms the watchdog and clears the count. No further pulse occurs until the key is written again.
- R7: Writes to any address other than SVC_ADDR do not change the key state. A key byte sent to another address does not count toward the key.
- R8: A completed key while armed restarts the count from zero. If the key completes on the same edge as a tick, the restart wins and that tick is not counted.
- R9: No SVC_ADDR write other than a completed key disarms the watchdog or changes its count.
- R10: An overflow also returns the key sequence to waiting for KEY_A. A KEY_A written before the overflow cannot be completed by a KEY_B written after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide per machine cycle |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rst_req | output | 1 | Reset request pulse, high for PULSE_LEN cycles after overflow |

## Verification
The bench uses a 4-bit count, so overflow comes on the 15th tick, and a 3-cycle pulse. It sweeps the service point over every tick position from 1 to 14. In each case the next pulse must come exactly 15 ticks later, which shows that servicing restarts the count rather than pausing it. Malformed key patterns must all leave the block disarmed: a lone second byte, a wrong second byte, a repeated first byte, and a key split across addresses. A key interleaved with writes to other addresses must still arm. Further cases separate the remaining rules: garbage writes to the armed service address, idle clocks without strobes, a key that completes on a strobe edge, a half key left standing across an overflow, and reset during counting and during the pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    KEY_IDLE = 1'b0,
    KEY_HALF = 1'b1
  } key_st_t;
endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              key_ok
);
  key_st_t st;
  logic    hit;

  assign hit    = wr_en && (wr_addr == SVC_ADDR);
  assign key_ok = hit && (st == KEY_HALF) && (wr_data == KEY_B);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st <= KEY_IDLE;
    end else if (hit) begin
      // only a first byte from the idle state advances; anything else aborts
      st <= ((st == KEY_IDLE) && (wr_data == KEY_A)) ? KEY_HALF : KEY_IDLE;
    end
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mc_tick,
  input  logic             key_ok,
  output logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] LAST_M1 = {{(CNT_W-1){1'b1}}, 1'b0};

  assign ovf = armed && mc_tick && !key_ok && (cnt == LAST_M1);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (key_ok) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (ovf) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (armed && mc_tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  logic req_q;
  assign pulse = req_q;

  generate
    if (PULSE_LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= fire;
      end
    end else begin : g_multi
      logic [PW-1:0] left;
      always_ff @(posedge clk) begin
        if (rst) begin
          req_q <= 1'b0;
          left  <= '0;
        end else if (fire) begin
          req_q <= 1'b1;
          left  <= PW'(PULSE_LEN - 1);
        end else if (left != '0) begin
          left <= left - PW'(1);
        end else begin
          req_q <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W = 14,
  parameter int PULSE_LEN = 4,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_req
);
  logic             key_ok;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             ovf;

  wdog_keyseq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SVC_ADDR(SVC_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_key (
    .clk(clk), .rst(rst), .clr(ovf),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_ok(key_ok)
  );

  wdog_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .key_ok(key_ok),
    .armed(armed), .cnt(cnt), .ovf(ovf)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pls (
    .clk(clk), .rst(rst), .fire(ovf), .pulse(rst_req)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 14,
  parameter int PULSE_LEN = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mc_tick,
  input logic             key_ok,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             rst_req
);
  localparam int RW = $clog2(PULSE_LEN + 2) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)          run <= '0;
    else if (rst_req) run <= run + RW'(1);
    else              run <= '0;
  end

  p_quiet_reset_r1: assert property (@(posedge clk) rst |=> !rst_req);
  p_key_arms_r2: assert property (@(posedge clk) disable iff (rst)
    key_ok |=> (armed && cnt == '0));
  p_tick_adv_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && mc_tick && !key_ok && !ovf) |=> (cnt == $past(cnt) + CNT_W'(1)));
  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && !mc_tick && !key_ok) |=> $stable(cnt));
  p_fire_r4: assert property (@(posedge clk) disable iff (rst) ovf |=> rst_req);
  p_pulse_len_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst_req) && !$past(rst)) |-> (run == RW'(PULSE_LEN)));
  p_pulse_cap_r5: assert property (@(posedge clk) disable iff (rst)
    run <= RW'(PULSE_LEN));
  p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (!armed && cnt == '0));
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !armed |-> cnt == '0);
  p_stay_armed_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && !ovf) |=> armed);
endmodule

bind wdog_keyed wdog_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .mc_tick(mc_tick), .key_ok(key_ok),
  .armed(armed), .cnt(cnt), .ovf(ovf), .rst_req(rst_req)
);

// File: tb/sim_wdog_keyed.sv
`timescale 1ns/1ps
module sim_wdog_keyed;
  localparam int CW = 4;
  localparam int PL = 3;
  localparam int FIRE_AT = (1 << CW) - 1;
  localparam logic [7:0] SVC = 8'hA6;
  localparam logic [7:0] KA = 8'h1E;
  localparam logic [7:0] KB = 8'hE1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mc_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rst_req;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wdog_keyed #(.CNT_W(CW), .PULSE_LEN(PL)) u0 (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rst_req(rst_req)
  );

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic arm();
    wr(SVC, KA);
    wr(SVC, KB);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      mc_tick = 1'b1;
      @(negedge clk);
      mc_tick = 1'b0;
    end
  endtask

  // ticks until rst_req is first seen; 0 if never within limit
  task automatic to_fire(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      mc_tick = 1'b1;
      @(negedge clk);
      mc_tick = 1'b0;
      if (rst_req) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic pulse_len(output int l);
    l = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rst_req) l++;
      else break;
    end
  endtask

  task automatic drain();
    repeat (PL + 2) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    report();
    $finish;
  end

  initial begin
    int n;
    int l;
    repeat (3) @(negedge clk);
    chk(rst_req, 0, "R1 low in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(rst_req, 0, "R1 low after reset");
    to_fire(40, n);
    chk(n, 0, "R1 unarmed never fires");

    // basic arm and overflow
    arm();
    to_fire(40, n);
    chk(n, FIRE_AT, "R4 overflow tick count");
    pulse_len(l);
    chk(l, PL, "R5 pulse length");
    to_fire(40, n);
    chk(n, 0, "R6 disarmed after overflow");

    // malformed keys
    wr(SVC, KB);
    to_fire(20, n);
    chk(n, 0, "R2 lone second byte");
    wr(SVC, KA); wr(SVC, 8'h55); wr(SVC, KB);
    to_fire(20, n);
    chk(n, 0, "R2 wrong second byte aborts");
    wr(SVC, KA); wr(SVC, KA); wr(SVC, KB);
    to_fire(20, n);
    chk(n, 0, "R2 repeated first byte aborts");
    wr(8'hA7, KA); wr(SVC, KB);
    to_fire(20, n);
    chk(n, 0, "R7 first byte at other address");
    wr(8'hA7, KA); wr(8'hA7, KB);
    to_fire(20, n);
    chk(n, 0, "R7 key at other address");

    // interleaved writes elsewhere
    wr(SVC, KA); wr(8'h80, 8'h12); wr(8'hA5, KB); wr(SVC, KB);
    to_fire(40, n);
    chk(n, FIRE_AT, "R7 interleaved key arms");
    drain();

    // service sweep
    for (int s = 1; s < FIRE_AT; s++) begin
      arm();
      tick(s);
      arm();
      to_fire(40, n);
      chk(n, FIRE_AT, $sformatf("R8 service after %0d ticks", s));
      drain();
    end

    // garbage writes cannot disable
    arm();
    tick(5);
    wr(SVC, 8'h00); wr(SVC, 8'hFF); wr(SVC, KA); wr(SVC, 8'h00);
    to_fire(40, n);
    chk(n, FIRE_AT - 5, "R9 writes do not disarm or restart");
    drain();

    // strobe gating
    arm();
    repeat (30) @(negedge clk);
    to_fire(40, n);
    chk(n, FIRE_AT, "R3 only strobes count");
    drain();

    // key completes on a strobe edge
    arm();
    tick(7);
    wr(SVC, KA);
    mc_tick = 1'b1;
    wr(SVC, KB);
    mc_tick = 1'b0;
    to_fire(40, n);
    chk(n, FIRE_AT, "R8 service beats tick");
    drain();

    // overflow clears half key
    arm();
    wr(SVC, KA);
    to_fire(40, n);
    chk(n, FIRE_AT, "R10 fires with half key pending");
    drain();
    wr(SVC, KB);
    to_fire(40, n);
    chk(n, 0, "R10 half key lost at overflow");

    // reset while armed and during pulse
    arm();
    tick(10);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    to_fire(40, n);
    chk(n, 0, "R1 reset disarms");
    arm();
    to_fire(40, n);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(rst_req, 0, "R1 reset cuts pulse");

    report();
    $finish;
  end
endmodule